// File: doc/BRIEF.md
# Fractional PLL Output Rate Calculator

This block works out the output frequency of a fractional-N synthesizer from the raw values held in its divider fields. It takes the reference frequency in hertz together with five fields: the integer multiplier, the fractional numerator, the fractional denominator, the reference pre-divider code and the output post-divider code. A mode input selects fractional operation or integer-only operation. A single-cycle `start` pulse launches a calculation. A single-cycle `done` pulse returns the rate in hertz, along with an error flag.

Fractions do not always divide evenly. A short list of known-good settings is therefore checked first, and a match returns the exact rate listed for it. When no entry matches, the pre-divider and post-divider codes are decoded and the block forms one combined numerator and one combined denominator. A restoring divider then produces one quotient bit per clock.

Top module: `fpll_rate_calc`

## Requirements
- R1: With `frac_mode`=1 and no table match, `rate` = floor(N / D), where N = ref_hz × (mult_int × frac_den + frac_num) and D = frac_den × pre × post. Here pre and post are the decoded pre-divider and post-divider values.
- R2: With `frac_mode`=0 and no table match, `rate` = floor(ref_hz × mult_int / (pre × post)), and the values on `frac_num` and `frac_den` have no effect on the result.
- R3: A `pre_div` code of 0 is used as a divisor of 1, and any other code is used as its own value.
- R4: A `post_div` code of 0 divides by 2 and a code of 1 divides by 3. Every other code divides by its own value.
- R5: In fractional mode, the five fields are compared with a built-in list before any arithmetic is done. On a full match the listed rate is returned whatever `ref_hz` is. The list holds these entries, in the order rate/mult_int/frac_num/frac_den/pre_div/post_div:
  - 650000000/162/50/100/0/6
  - 594000000/198/0/1/0/8
  - 393216000/163/84/100/0/10
- R6: In integer mode only mult_int, pre_div and post_div are compared. The integer list holds these entries, in the order rate/mult_int/pre_div/post_div:
  - 1700000000/141/1/2
  - 1400000000/175/1/3
  - 900000000/150/1/4
- R7: The numerator N is kept to its low 64 bits (modulo 2^64). The quotient is unsigned and truncated toward zero.
- R8: If the combined denominator is zero, the block does not divide. It returns `rate`=0 with `err`=1 in the `done` cycle. `err` is 0 on every other completion.
- R9: A `start` that arrives while `busy`=1 is ignored. The calculation in progress finishes with its own fields, and no extra completion follows it.
- R10: `done` is high for exactly one cycle, with `rate` and `err` valid in that same cycle. `busy` is 1 from the cycle after an accepted `start` until `done`, and `busy` is 0 in the `done` cycle.
- R11: After reset, `busy`, `done`, `err` and `rate` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse; taken only while idle |
| frac_mode | input | 1 | 1 = fractional operation, 0 = integer only |
| ref_hz | input | 32 | Reference frequency in Hz |
| mult_int | input | 9 | Integer multiplier field |
| frac_num | input | 30 | Fractional numerator field |
| frac_den | input | 30 | Fractional denominator field |
| pre_div | input | 3 | Reference pre-divider code |
| post_div | input | 8 | Output post-divider code |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Zero-denominator flag, valid with done |
| rate | output | 64 | Result in Hz, valid with done and held afterwards |

## Verification
The assertions check the following on every cycle:
- the one-cycle shape of `done`;
- that `done` never coincides with `busy`;
- that an error completion always carries a zero rate;
- that the captured fields stay frozen while busy, so a stray `start` cannot re-enter the lookup;
- the divider's invariant that the partial remainder stays below the divisor.

The arithmetic itself can only be shown by the bench's scenarios:
- table hits that differ from the formula;
- the near misses that fall through to the divider;
- the decoding of the pre-divider and post-divider codes;
- truncation and 64-bit wraparound;
- a zero denominator in fractional mode.

// File: rtl/fpll_pkg.sv
package fpll_pkg;
  localparam int REF_W  = 32;
  localparam int MINT_W = 9;
  localparam int FNUM_W = 30;
  localparam int FDEN_W = 30;
  localparam int PRE_W  = 3;
  localparam int POST_W = 8;
  localparam int TRATE_W = 32;
  localparam int TAB_N  = 6;

  typedef struct packed {
    logic [TRATE_W-1:0] rate;
    logic               int_only;
    logic [MINT_W-1:0]  mint;
    logic [FNUM_W-1:0]  fnum;
    logic [FDEN_W-1:0]  fden;
    logic [PRE_W-1:0]   pre;
    logic [POST_W-1:0]  post;
  } tab_entry_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_MUL, ST_DIV} calc_state_t;

  function automatic tab_entry_t mk_entry(input logic [TRATE_W-1:0] r, input logic io,
                                          input int mi, input int fn, input int fd,
                                          input int pr, input int po);
    tab_entry_t e;
    e.rate     = r;
    e.int_only = io;
    e.mint     = MINT_W'(mi);
    e.fnum     = FNUM_W'(fn);
    e.fden     = FDEN_W'(fd);
    e.pre      = PRE_W'(pr);
    e.post     = POST_W'(po);
    return e;
  endfunction

  // Known-good settings: three fractional, three integer-only.
  function automatic tab_entry_t tab_entry(input int idx);
    case (idx)
      0:       return mk_entry(32'd650000000,  1'b0, 162, 50, 100, 0, 6);
      1:       return mk_entry(32'd594000000,  1'b0, 198, 0,  1,   0, 8);
      2:       return mk_entry(32'd393216000,  1'b0, 163, 84, 100, 0, 10);
      3:       return mk_entry(32'd1700000000, 1'b1, 141, 0,  0,   1, 2);
      4:       return mk_entry(32'd1400000000, 1'b1, 175, 0,  0,   1, 3);
      default: return mk_entry(32'd900000000,  1'b1, 150, 0,  0,   1, 4);
    endcase
  endfunction
endpackage

// File: rtl/fpll_tab_match.sv
module fpll_tab_match
  import fpll_pkg::*;
(
  input  logic               frac_mode,
  input  logic [MINT_W-1:0]  mint,
  input  logic [FNUM_W-1:0]  fnum,
  input  logic [FDEN_W-1:0]  fden,
  input  logic [PRE_W-1:0]   pre,
  input  logic [POST_W-1:0]  post,
  output logic               hit,
  output logic [TRATE_W-1:0] hit_rate
);
  logic [TAB_N-1:0]   hit_vec;
  logic [TRATE_W-1:0] rate_vec [TAB_N];

  for (genvar i = 0; i < TAB_N; i++) begin : g_ent
    tab_entry_t ent;
    logic       frac_ok;
    assign ent     = tab_entry(i);
    // integer-only entries ignore the fractional fields
    assign frac_ok = ent.int_only | ((fnum == ent.fnum) & (fden == ent.fden));
    assign hit_vec[i] = (ent.int_only == ~frac_mode) & (mint == ent.mint) &
                        (pre == ent.pre) & (post == ent.post) & frac_ok;
    assign rate_vec[i] = hit_vec[i] ? ent.rate : '0;
  end

  always_comb begin
    hit      = |hit_vec;
    hit_rate = '0;
    for (int i = 0; i < TAB_N; i++) hit_rate = hit_rate | rate_vec[i];
  end
endmodule

// File: rtl/fpll_operand_build.sv
module fpll_operand_build
  import fpll_pkg::*;
#(
  parameter int NUM_W = 64,
  parameter int DEN_W = FDEN_W + PRE_W + POST_W
)(
  input  logic              frac_mode,
  input  logic [REF_W-1:0]  ref_hz,
  input  logic [MINT_W-1:0] mint,
  input  logic [FNUM_W-1:0] fnum,
  input  logic [FDEN_W-1:0] fden,
  input  logic [PRE_W-1:0]  pre,
  input  logic [POST_W-1:0] post,
  output logic [NUM_W-1:0]  num,
  output logic [DEN_W-1:0]  den
);
  localparam int FACT_W = MINT_W + FDEN_W + 1;
  localparam int PROD_W = REF_W + FACT_W;
  localparam int DIVS_W = PRE_W + POST_W;

  logic [PRE_W-1:0]  pre_eff;
  logic [POST_W-1:0] post_eff;
  logic [DIVS_W-1:0] divs;
  logic [FACT_W-1:0] factor;
  logic [PROD_W-1:0] prod;

  always_comb begin
    pre_eff = (pre == '0) ? PRE_W'(1) : pre;
    case (post)
      POST_W'(0): post_eff = POST_W'(2);
      POST_W'(1): post_eff = POST_W'(3);
      default:    post_eff = post;
    endcase
    divs = DIVS_W'(pre_eff) * DIVS_W'(post_eff);
    if (frac_mode) begin
      factor = FACT_W'(mint) * FACT_W'(fden) + FACT_W'(fnum);
      den    = DEN_W'(fden) * DEN_W'(divs);
    end else begin
      factor = FACT_W'(mint);
      den    = DEN_W'(divs);
    end
    prod = PROD_W'(ref_hz) * PROD_W'(factor);
    num  = NUM_W'(prod);
  end
endmodule

// File: rtl/fpll_restoring_div.sv
module fpll_restoring_div #(
  parameter int NUM_W = 64,
  parameter int DEN_W = 41
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [NUM_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             take;

  always_comb begin
    trial = {rem_q, quo_q[NUM_W-1]};
    diff  = trial - {1'b0, den_q};
    take  = ~diff[DEN_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      den_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem_q <= '0;
        den_q <= den;
        quo_q <= num;
        cnt_q <= CNT_W'(NUM_W);
      end else if (cnt_q != '0) begin
        rem_q <= take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], take};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) done <= 1'b1;
      end
    end
  end

  assign busy = (cnt_q != '0);
  assign quo  = quo_q;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (busy && den_q != '0) |-> (rem_q < den_q)); // R7
  AST_DIV_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7
endmodule

// File: rtl/fpll_rate_calc.sv
module fpll_rate_calc
  import fpll_pkg::*;
#(
  parameter int NUM_W = 64
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              frac_mode,
  input  logic [REF_W-1:0]  ref_hz,
  input  logic [MINT_W-1:0] mult_int,
  input  logic [FNUM_W-1:0] frac_num,
  input  logic [FDEN_W-1:0] frac_den,
  input  logic [PRE_W-1:0]  pre_div,
  input  logic [POST_W-1:0] post_div,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [NUM_W-1:0]  rate
);
  localparam int DEN_W = FDEN_W + PRE_W + POST_W;

  calc_state_t       state_q;
  logic              frac_q;
  logic [REF_W-1:0]  ref_q;
  logic [MINT_W-1:0] mint_q;
  logic [FNUM_W-1:0] fnum_q;
  logic [FDEN_W-1:0] fden_q;
  logic [PRE_W-1:0]  pre_q;
  logic [POST_W-1:0] post_q;
  logic [NUM_W-1:0]  num_q;
  logic [DEN_W-1:0]  den_q;
  logic              div_go_q;
  logic              done_q;
  logic              err_q;
  logic [NUM_W-1:0]  rate_q;

  logic               tab_hit;
  logic [TRATE_W-1:0] tab_rate;
  logic [NUM_W-1:0]   b_num;
  logic [DEN_W-1:0]   b_den;
  logic               div_busy;
  logic               div_done;
  logic [NUM_W-1:0]   div_quo;

  fpll_tab_match u_match (
    .frac_mode (frac_q),
    .mint      (mint_q),
    .fnum      (fnum_q),
    .fden      (fden_q),
    .pre       (pre_q),
    .post      (post_q),
    .hit       (tab_hit),
    .hit_rate  (tab_rate)
  );

  fpll_operand_build #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_build (
    .frac_mode (frac_q),
    .ref_hz    (ref_q),
    .mint      (mint_q),
    .fnum      (fnum_q),
    .fden      (fden_q),
    .pre       (pre_q),
    .post      (post_q),
    .num       (b_num),
    .den       (b_den)
  );

  fpll_restoring_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .go   (div_go_q),
    .num  (num_q),
    .den  (den_q),
    .busy (div_busy),
    .done (div_done),
    .quo  (div_quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      frac_q   <= 1'b0;
      ref_q    <= '0;
      mint_q   <= '0;
      fnum_q   <= '0;
      fden_q   <= '0;
      pre_q    <= '0;
      post_q   <= '0;
      num_q    <= '0;
      den_q    <= '0;
      div_go_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rate_q   <= '0;
    end else begin
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      div_go_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            frac_q  <= frac_mode;
            ref_q   <= ref_hz;
            mint_q  <= mult_int;
            fnum_q  <= frac_num;
            fden_q  <= frac_den;
            pre_q   <= pre_div;
            post_q  <= post_div;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (tab_hit) begin
            rate_q  <= NUM_W'(tab_rate);
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_MUL;
          end
        end
        ST_MUL: begin
          num_q <= b_num;
          den_q <= b_den;
          if (b_den == '0) begin
            rate_q  <= '0;
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            div_go_q <= 1'b1;
            state_q  <= ST_DIV;
          end
        end
        default: begin
          if (div_done) begin
            rate_q  <= div_quo;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;
  assign rate = rate_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy); // R10
  AST_ERR_ZERO_RATE: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (done_q && rate_q == '0)); // R8
  AST_INT_NEVER_ERR: assert property (@(posedge clk) disable iff (rst)
    (done_q && !frac_q) |-> !err_q); // R2
  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(mint_q) && $stable(fnum_q) && $stable(fden_q) &&
              $stable(pre_q) && $stable(post_q) && $stable(ref_q) && $stable(frac_q))); // R9
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (state_q != ST_LOOK)); // R9
  AST_DIV_ONLY_IN_DIV: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> (state_q == ST_DIV)); // R1
endmodule

// File: tb/fpll_rate_calc_tb.sv
module fpll_rate_calc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        frac_mode = 1'b0;
  logic [31:0] ref_hz = '0;
  logic [8:0]  mult_int = '0;
  logic [29:0] frac_num = '0;
  logic [29:0] frac_den = '0;
  logic [2:0]  pre_div = '0;
  logic [7:0]  post_div = '0;
  logic        busy, done, err;
  logic [63:0] rate;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  fpll_rate_calc u_dut (
    .clk(clk), .rst(rst), .start(start), .frac_mode(frac_mode), .ref_hz(ref_hz),
    .mult_int(mult_int), .frac_num(frac_num), .frac_den(frac_den),
    .pre_div(pre_div), .post_div(post_div),
    .busy(busy), .done(done), .err(err), .rate(rate)
  );

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Independent model of the requirements (R1..R8)
  function automatic logic [63:0] model(input logic fm, input logic [31:0] rf,
      input logic [8:0] mi, input logic [29:0] fn, input logic [29:0] fd,
      input logic [2:0] pr, input logic [7:0] po, output logic e);
    logic [127:0] n, d, pv, ov;
    e = 1'b0;
    if (fm) begin
      if (mi == 162 && fn == 50 && fd == 100 && pr == 0 && po == 6)  return 64'd650000000;
      if (mi == 198 && fn == 0  && fd == 1   && pr == 0 && po == 8)  return 64'd594000000;
      if (mi == 163 && fn == 84 && fd == 100 && pr == 0 && po == 10) return 64'd393216000;
    end else begin
      if (mi == 141 && pr == 1 && po == 2) return 64'd1700000000;
      if (mi == 175 && pr == 1 && po == 3) return 64'd1400000000;
      if (mi == 150 && pr == 1 && po == 4) return 64'd900000000;
    end
    pv = (pr == 0) ? 128'd1 : 128'(pr);
    ov = (po == 0) ? 128'd2 : (po == 1) ? 128'd3 : 128'(po);
    if (fm) begin
      n = 128'(rf) * (128'(mi) * 128'(fd) + 128'(fn));
      d = 128'(fd) * pv * ov;
    end else begin
      n = 128'(rf) * 128'(mi);
      d = pv * ov;
    end
    n = {64'd0, n[63:0]};
    if (d == 0) begin
      e = 1'b1;
      return 64'd0;
    end
    return 64'(n / d);
  endfunction

  task automatic drive(input logic fm, input logic [31:0] rf, input logic [8:0] mi,
                       input logic [29:0] fn, input logic [29:0] fd,
                       input logic [2:0] pr, input logic [7:0] po);
    frac_mode = fm; ref_hz = rf; mult_int = mi; frac_num = fn;
    frac_den = fd; pre_div = pr; post_div = po;
  endtask

  // Launch one calculation and check result, error flag and done shape
  task automatic run_calc(input string req, input logic fm, input logic [31:0] rf,
                          input logic [8:0] mi, input logic [29:0] fn, input logic [29:0] fd,
                          input logic [2:0] pr, input logic [7:0] po);
    logic [63:0] exp_r;
    logic        exp_e;
    logic        got;
    logic [63:0] got_r;
    logic        got_e;
    exp_r = model(fm, rf, mi, fn, fd, pr, po, exp_e);
    @(negedge clk);
    drive(fm, rf, mi, fn, fd, pr, po);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10", "busy after start", 64'(busy), 64'd1);
    got = 1'b0; got_r = '0; got_e = 1'b0;
    for (int i = 0; i < 200 && !got; i++) begin
      if (done) begin
        got = 1'b1; got_r = rate; got_e = err;
        check("R10", "busy low in done cycle", 64'(busy), 64'd0);
      end else @(negedge clk);
    end
    check("R10", "done seen", 64'(got), 64'd1);
    check(req, "rate", got_r, exp_r);
    check("R8", "err flag", 64'(got_e), 64'(exp_e));
    @(negedge clk);
    check("R10", "done one cycle", 64'(done), 64'd0);
    check("R10", "rate held", rate, exp_r);
  endtask

  task automatic t_reset;
    check("R11", "busy", 64'(busy), 64'd0);
    check("R11", "done", 64'(done), 64'd0);
    check("R11", "err",  64'(err),  64'd0);
    check("R11", "rate", rate, 64'd0);
  endtask

  task automatic t_frac_table;
    run_calc("R5", 1'b1, 32'd24000000, 9'd162, 30'd50, 30'd100, 3'd0, 8'd6);
    run_calc("R5", 1'b1, 32'd24000000, 9'd198, 30'd0, 30'd1, 3'd0, 8'd8);
    // listed rate wins even though the reference differs
    run_calc("R5", 1'b1, 32'd25000000, 9'd163, 30'd84, 30'd100, 3'd0, 8'd10);
    check("R5", "table ignores ref", rate, 64'd393216000);
  endtask

  task automatic t_frac_compute;
    run_calc("R1", 1'b1, 32'd24000000, 9'd162, 30'd50, 30'd101, 3'd0, 8'd6);
    run_calc("R1", 1'b1, 32'd19200000, 9'd100, 30'd1, 30'd3, 3'd2, 8'd5);
  endtask

  task automatic t_int_modes;
    // table hit with junk fractional fields: 24 MHz formula would give 1692000000
    run_calc("R6", 1'b0, 32'd24000000, 9'd141, 30'd777, 30'd0, 3'd1, 8'd2);
    check("R6", "int table rate", rate, 64'd1700000000);
    run_calc("R6", 1'b0, 32'd24000000, 9'd150, 30'd0, 30'd0, 3'd1, 8'd4);
    run_calc("R2", 1'b0, 32'd24000000, 9'd100, 30'd0, 30'd0, 3'd2, 8'd10);
    check("R2", "int formula", rate, 64'd120000000);
    run_calc("R2", 1'b0, 32'd24000000, 9'd100, 30'd5, 30'd7, 3'd2, 8'd10);
    check("R2", "frac fields ignored", rate, 64'd120000000);
  endtask

  task automatic t_pre_decode;
    logic [63:0] r0;
    run_calc("R3", 1'b0, 32'd24000000, 9'd50, 30'd0, 30'd0, 3'd0, 8'd4);
    r0 = rate;
    run_calc("R3", 1'b0, 32'd24000000, 9'd50, 30'd0, 30'd0, 3'd1, 8'd4);
    check("R3", "pre code 0 equals 1", rate, r0);
    run_calc("R3", 1'b1, 32'd24000000, 9'd50, 30'd1, 30'd2, 3'd0, 8'd4);
  endtask

  task automatic t_post_decode;
    run_calc("R4", 1'b0, 32'd24000000, 9'd60, 30'd0, 30'd0, 3'd1, 8'd0);
    check("R4", "post code 0 -> /2", rate, 64'd720000000);
    run_calc("R4", 1'b0, 32'd24000000, 9'd60, 30'd0, 30'd0, 3'd1, 8'd1);
    check("R4", "post code 1 -> /3", rate, 64'd480000000);
    run_calc("R4", 1'b0, 32'd24000000, 9'd60, 30'd0, 30'd0, 3'd1, 8'd2);
    check("R4", "post code 2 -> /2", rate, 64'd720000000);
  endtask

  task automatic t_trunc;
    run_calc("R7", 1'b1, 32'd24000000, 9'd100, 30'd1, 30'd7, 3'd3, 8'd9);
    run_calc("R7", 1'b1, 32'hFFFFFFFF, 9'd511, 30'h3FFFFFFF, 30'h3FFFFFFE, 3'd7, 8'd255);
    run_calc("R7", 1'b0, 32'd7, 9'd1, 30'd0, 30'd0, 3'd1, 8'd2);
    check("R7", "7/2 truncates", rate, 64'd3);
  endtask

  task automatic t_zero_den;
    run_calc("R8", 1'b1, 32'd24000000, 9'd100, 30'd5, 30'd0, 3'd0, 8'd4);
    run_calc("R8", 1'b1, 32'd24000000, 9'd100, 30'd1, 30'd3, 3'd0, 8'd4);
  endtask

  task automatic t_busy_start;
    logic [63:0] exp_r;
    logic        exp_e;
    int          extra;
    exp_r = model(1'b1, 32'd24000000, 9'd100, 30'd1, 30'd9, 3'd1, 8'd4, exp_e);
    @(negedge clk);
    drive(1'b1, 32'd24000000, 9'd100, 30'd1, 30'd9, 3'd1, 8'd4);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    drive(1'b0, 32'd24000000, 9'd141, 30'd0, 30'd0, 3'd1, 8'd2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
    check("R9", "first job result", rate, exp_r);
    extra = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R9", "no extra completion", 64'(extra), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_frac_table();
    t_frac_compute();
    t_int_modes();
    t_pre_decode();
    t_post_decode();
    t_trunc();
    t_zero_den();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule